// File: doc/BRIEF.md
# Segment Register Address Translator

This block widens 32-bit logical addresses into 52-bit interim virtual addresses ahead of a page lookup stage. The logical space is cut into sixteen fixed 256-Mbyte segments. The top four address bits pick one of sixteen segment registers, and each register supplies a 24-bit virtual segment identifier. The result is handed on as a 40-bit virtual page number, made of the identifier followed by the 16-bit page index, plus the untranslated 12-bit byte offset of the 4-Kbyte page.

Two request ports work side by side, one for instruction fetches and one for load/store data. Each can accept one request per cycle, and each has a registered result one cycle later. A request that lands in an invalid segment is flagged as a fault instead of producing a valid result. A fetch from a segment marked no-execute is also flagged as a fault.

Software loads the segment registers through a write port that carries the privilege state of the writer. Only supervisor writes take effect. A user write leaves the table untouched and raises a one-cycle privilege-error pulse.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset every output is low and all sixteen segments are invalid, so any request that follows faults until a segment is written.
- R2: For a request accepted at a clock edge, the next cycle shows the result. `*_vpn` equals the 24-bit identifier of the segment chosen by address bits 31:28, followed by address bits 27:12, and `*_off` equals address bits 11:0.
- R3: The fetch port and the data port translate independently in the same cycle, even when they use different segments.
- R4: A request on either port to a segment whose valid bit is 0 gives `*_fault`=1 and `*_vld`=0 in the result cycle.
- R5: A fetch to a valid segment whose no-execute bit is 1 faults. A data access to that segment translates normally.
- R6: A write with `wr_sup`=0 leaves the segment table unchanged and drives `wr_priv_err` high for exactly the following cycle. A supervisor write gives no pulse.
- R7: A supervisor write at a clock edge affects requests accepted from the next edge on. A request accepted at the same edge as the write uses the old contents.
- R8: A cycle without a request gives `*_vld`=0 and `*_fault`=0 on that port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sup | input | 1 | Writer is in supervisor state |
| wr_idx | input | 4 | Segment register to write |
| wr_vsid | input | 24 | Virtual segment identifier to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_noexec | input | 1 | No-execute bit to store |
| wr_priv_err | output | 1 | One-cycle pulse after a rejected user write |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 32 | Fetch logical address |
| if_vld | output | 1 | Fetch result valid |
| if_fault | output | 1 | Fetch faulted (invalid or no-execute segment) |
| if_vpn | output | 40 | Fetch virtual page number |
| if_off | output | 12 | Fetch byte offset |
| dt_req | input | 1 | Data access request |
| dt_addr | input | 32 | Data logical address |
| dt_vld | output | 1 | Data result valid |
| dt_fault | output | 1 | Data faulted (invalid segment) |
| dt_vpn | output | 40 | Data virtual page number |
| dt_off | output | 12 | Data byte offset |

## Verification
The hardest case to reach from the ports is the update boundary. A request must arrive in exactly the cycle a segment register is rewritten, and a second request must use that same segment one cycle later. Only then can the old and new contents be told apart. The stimulus drives a supervisor write and a data request to the written segment in the same cycle, then repeats the request in the next cycle. The scoreboard model applies each write only after it has computed the expectations for that cycle. User writes aimed at an already programmed segment are followed at once by requests to it, which shows at the ports that the identifier did not change.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LA_W    = 32;
    localparam int SEL_W   = 4;
    localparam int NUM_SEG = 1 << SEL_W;
    localparam int OFF_W   = 12;
    localparam int PIDX_W  = LA_W - SEL_W - OFF_W;
    localparam int VSID_W  = 24;
    localparam int VPN_W   = VSID_W + PIDX_W;
    localparam int VA_W    = VPN_W + OFF_W;

    typedef struct packed {
        logic              valid;
        logic              noexec;
        logic [VSID_W-1:0] vsid;
    } seg_entry_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PIDX_W-1:0] pidx;
        logic [OFF_W-1:0]  off;
    } laddr_t;

    typedef enum logic [1:0] {
        ACC_OK      = 2'd0,
        ACC_INVALID = 2'd1,
        ACC_NOEXEC  = 2'd2
    } acc_status_e;

    function automatic acc_status_e seg_check(input seg_entry_t ent, input bit is_fetch);
        if (!ent.valid)
            return ACC_INVALID;
        if (is_fetch && ent.noexec)
            return ACC_NOEXEC;
        return ACC_OK;
    endfunction

endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_xlate_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic                      wr_sup_i,
    input  logic [SEL_W-1:0]          wr_idx_i,
    input  seg_entry_t                wr_entry_i,
    output seg_entry_t [NUM_SEG-1:0]  table_o,
    output logic                      priv_err_o
);

    logic wr_ok;
    assign wr_ok = wr_en_i && wr_sup_i;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                table_o[g] <= '0;
            else if (wr_ok && (wr_idx_i == SEL_W'(g)))
                table_o[g] <= wr_entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            priv_err_o <= 1'b0;
        else
            priv_err_o <= wr_en_i && !wr_sup_i;
    end

    AST_USER_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_sup_i) |=> (table_o == $past(table_o))) else $error("user write changed table"); // R6
    AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_sup_i) |=> priv_err_o) else $error("missing privilege pulse"); // R6
    AST_SUP_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i || wr_sup_i) |=> !priv_err_o) else $error("spurious privilege pulse"); // R6

endmodule

// File: rtl/seg_port_xlate.sv
module seg_port_xlate
    import seg_xlate_pkg::*;
#(
    parameter bit IS_FETCH = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_i,
    input  logic [LA_W-1:0]           addr_i,
    input  seg_entry_t [NUM_SEG-1:0]  table_i,
    output logic                      vld_o,
    output logic                      fault_o,
    output logic [VPN_W-1:0]          vpn_o,
    output logic [OFF_W-1:0]          off_o
);

    laddr_t      lad;
    seg_entry_t  ent;
    acc_status_e status;

    always_comb begin
        lad    = laddr_t'(addr_i);
        ent    = table_i[lad.sel];
        status = seg_check(ent, IS_FETCH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            fault_o <= 1'b0;
            vpn_o   <= '0;
            off_o   <= '0;
        end else begin
            vld_o   <= req_i && (status == ACC_OK);
            fault_o <= req_i && (status != ACC_OK);
            vpn_o   <= {ent.vsid, lad.pidx};
            off_o   <= lad.off;
        end
    end

    AST_VLD_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(vld_o && fault_o)) else $error("valid and fault together"); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!vld_o && !fault_o)) else $error("output without request"); // R8
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        req_i |=> (off_o == $past(addr_i[OFF_W-1:0]))) else $error("offset altered"); // R2
    AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (req_i && !ent.valid) |=> (fault_o && !vld_o)) else $error("invalid segment not flagged"); // R4
    AST_NOEXEC_FETCH: assert property (@(posedge clk) disable iff (rst)
        (IS_FETCH && req_i && ent.valid && ent.noexec) |=> fault_o) else $error("no-execute fetch not flagged"); // R5

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sup,
    input  logic [SEL_W-1:0]   wr_idx,
    input  logic [VSID_W-1:0]  wr_vsid,
    input  logic               wr_valid,
    input  logic               wr_noexec,
    output logic               wr_priv_err,
    input  logic               if_req,
    input  logic [LA_W-1:0]    if_addr,
    output logic               if_vld,
    output logic               if_fault,
    output logic [VPN_W-1:0]   if_vpn,
    output logic [OFF_W-1:0]   if_off,
    input  logic               dt_req,
    input  logic [LA_W-1:0]    dt_addr,
    output logic               dt_vld,
    output logic               dt_fault,
    output logic [VPN_W-1:0]   dt_vpn,
    output logic [OFF_W-1:0]   dt_off
);

    seg_entry_t                wr_entry;
    seg_entry_t [NUM_SEG-1:0]  seg_table;

    assign wr_entry = '{valid: wr_valid, noexec: wr_noexec, vsid: wr_vsid};

    seg_reg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_sup_i   (wr_sup),
        .wr_idx_i   (wr_idx),
        .wr_entry_i (wr_entry),
        .table_o    (seg_table),
        .priv_err_o (wr_priv_err)
    );

    seg_port_xlate #(.IS_FETCH(1'b1)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .req_i   (if_req),
        .addr_i  (if_addr),
        .table_i (seg_table),
        .vld_o   (if_vld),
        .fault_o (if_fault),
        .vpn_o   (if_vpn),
        .off_o   (if_off)
    );

    seg_port_xlate #(.IS_FETCH(1'b0)) u_data (
        .clk     (clk),
        .rst     (rst),
        .req_i   (dt_req),
        .addr_i  (dt_addr),
        .table_i (seg_table),
        .vld_o   (dt_vld),
        .fault_o (dt_fault),
        .vpn_o   (dt_vpn),
        .off_o   (dt_off)
    );

    AST_DATA_IGNORES_NOEXEC: assert property (@(posedge clk) disable iff (rst)
        (dt_req && seg_table[dt_addr[LA_W-1 -: SEL_W]].valid) |=> (dt_vld && !dt_fault)) else $error("data access wrongly faulted"); // R5

endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sup = 1'b0, wr_valid = 1'b0, wr_noexec = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [23:0] wr_vsid = '0;
    logic        wr_priv_err;
    logic        if_req = 1'b0, dt_req = 1'b0;
    logic [31:0] if_addr = '0, dt_addr = '0;
    logic        if_vld, if_fault, dt_vld, dt_fault;
    logic [39:0] if_vpn, dt_vpn;
    logic [11:0] if_off, dt_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sup(wr_sup), .wr_idx(wr_idx), .wr_vsid(wr_vsid),
        .wr_valid(wr_valid), .wr_noexec(wr_noexec), .wr_priv_err(wr_priv_err),
        .if_req(if_req), .if_addr(if_addr), .if_vld(if_vld), .if_fault(if_fault),
        .if_vpn(if_vpn), .if_off(if_off),
        .dt_req(dt_req), .dt_addr(dt_addr), .dt_vld(dt_vld), .dt_fault(dt_fault),
        .dt_vpn(dt_vpn), .dt_off(dt_off)
    );

    typedef struct {
        logic        vld;
        logic        fault;
        logic [39:0] vpn;
        logic [11:0] off;
        string       tag;
    } exp_t;

    typedef struct {
        logic  perr;
        string tag;
    } exp_pe_t;

    exp_t    q_if[$];
    exp_t    q_dt[$];
    exp_pe_t q_pe[$];

    logic        m_valid [16];
    logic        m_noexec[16];
    logic [23:0] m_vsid  [16];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    function automatic exp_t predict(input logic req, input logic [31:0] a, input bit fetch, input string tag);
        exp_t e;
        logic ok;
        ok      = m_valid[a[31:28]] && !(fetch && m_noexec[a[31:28]]);
        e.vld   = req && ok;
        e.fault = req && !ok;
        e.vpn   = {m_vsid[a[31:28]], a[27:12]};
        e.off   = a[11:0];
        e.tag   = tag;
        return e;
    endfunction

    task automatic drive(input logic ir, input logic [31:0] ia,
                         input logic dr, input logic [31:0] da,
                         input logic we, input logic ws, input logic [3:0] wi,
                         input logic [23:0] wv, input logic wval, input logic wnx,
                         input string tag);
        exp_pe_t p;
        @(negedge clk);
        if_req = ir; if_addr = ia; dt_req = dr; dt_addr = da;
        wr_en = we; wr_sup = ws; wr_idx = wi; wr_vsid = wv; wr_valid = wval; wr_noexec = wnx;
        q_if.push_back(predict(ir, ia, 1'b1, tag));
        q_dt.push_back(predict(dr, da, 1'b0, tag));
        p.perr = we && !ws;
        p.tag  = tag;
        q_pe.push_back(p);
        if (we && ws) begin
            m_valid[wi]  = wval;
            m_noexec[wi] = wnx;
            m_vsid[wi]   = wv;
        end
    endtask

    task automatic idle(input string tag);
        drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic cmp_port(input string pname, input exp_t e, input logic v, input logic f,
                            input logic [39:0] vpn, input logic [11:0] off);
        tests++;
        if (v !== e.vld || f !== e.fault || (e.vld && (vpn !== e.vpn || off !== e.off))) begin
            fails++;
            $display("FAIL %s %s: got vld=%b fault=%b vpn=%h off=%h, expected vld=%b fault=%b vpn=%h off=%h",
                     e.tag, pname, v, f, vpn, off, e.vld, e.fault, e.vpn, e.off);
        end
    endtask

    // Monitor: results of the requests driven at the previous falling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_if.size() > 0) cmp_port("fetch", q_if.pop_front(), if_vld, if_fault, if_vpn, if_off);
            if (q_dt.size() > 0) cmp_port("data",  q_dt.pop_front(), dt_vld, dt_fault, dt_vpn, dt_off);
            if (q_pe.size() > 0) begin
                exp_pe_t p;
                p = q_pe.pop_front();
                tests++;
                if (wr_priv_err !== p.perr) begin
                    fails++;
                    $display("FAIL %s priv: got wr_priv_err=%b, expected %b", p.tag, wr_priv_err, p.perr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_noexec[i] = 1'b0; m_vsid[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the outputs
        tests++;
        if ({if_vld, if_fault, dt_vld, dt_fault, wr_priv_err} !== 5'b0 || if_vpn !== '0 || dt_off !== '0) begin
            fails++;
            $display("FAIL R1 reset: got %b, expected 00000", {if_vld, if_fault, dt_vld, dt_fault, wr_priv_err});
        end
        rst = 1'b0;

        // R1 / R4: every segment invalid after reset
        drive(1'b1, 32'h3000_0123, 1'b1, 32'hF456_7ABC, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R1");
        // R7: write segment 3 while a request to it is in the same cycle -> old contents
        drive(1'b0, '0, 1'b1, 32'h3ABC_D123, 1'b1, 1'b1, 4'd3, 24'hABCDEF, 1'b1, 1'b0, "R7");
        // R7 / R2: one cycle later the new identifier is in use
        drive(1'b1, 32'h3123_4FFF, 1'b1, 32'h3ABC_D123, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R7");
        // R8: idle ports stay quiet
        idle("R8");
        idle("R8");
        // R5: no-execute segment
        drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 4'hF, 24'h123456, 1'b1, 1'b1, "R5");
        drive(1'b1, 32'hF000_0004, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R5");
        // R6: user write rejected, pulse, table unchanged at the ports
        drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 4'd3, 24'h000001, 1'b0, 1'b1, "R6");
        drive(1'b1, 32'h3000_0000, 1'b1, 32'h3FFF_F001, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R6");
        // R6: user write to an invalid segment does not make it valid
        drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 4'd7, 24'h777777, 1'b1, 1'b0, "R6");
        drive(1'b1, 32'h7000_1000, 1'b1, 32'h7000_2000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R6");

        // R2 / R3: program all segments, then translate on both ports at once
        for (int i = 0; i < 16; i++)
            drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 4'(i), 24'h100000 + 24'(i * 24'h01F3A7),
                  1'b1, (i == 9), "R2");
        for (int i = 0; i < 16; i++)
            drive(1'b1, {4'(i), 16'(i * 4099 + 5), 12'(i * 291)},
                  1'b1, {4'(15 - i), 16'(i * 733), 12'(4095 - i)},
                  1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R3");

        // R4: invalidate segment 5 and access it from both ports
        drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b1, 4'd5, 24'hFFFFFF, 1'b0, 1'b0, "R4");
        drive(1'b1, 32'h5555_5555, 1'b1, 32'h5000_0000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R4");
        // R5: data port still translates segment 9 (no-execute), fetch faults
        drive(1'b1, 32'h9ABC_0123, 1'b1, 32'h9ABC_0123, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R5");
        // R8: a request on one port only
        drive(1'b0, 32'h1000_0000, 1'b1, 32'h1000_0000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, "R8");
        idle("R8");
        idle("R8");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule